// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This purely combinational unit sits beside the execute stage of a five-stage in-order pipeline. For both ALU operands of the instruction now in execute, it decides where the operand comes from. The candidates are the result still in the memory-stage register, the result in the write-back register, or the value read from the register file during decode. It also watches the instruction being decoded. When that instruction needs a register that a load in execute has not yet fetched, the unit freezes the fetch side for one cycle and sends an empty slot down the pipe.

The select codes drive the two operand multiplexers in the execute stage. The three stall lines drive the PC write enable, the fetch/decode register write enable and the clear of the control fields entering execute. All outputs depend only on the present contents of the pipeline registers, so they are valid in the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `fwd_a` is 2'b10 (memory-stage result) whenever `mem_wen` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs`.
- R2: `fwd_b` is 2'b10 under the same rule, with `mem_rd` compared against `ex_rt`.
- R3: An operand select is 2'b01 (write-back result) when `wb_wen` is 1, `wb_rd` is nonzero, `wb_rd` equals that operand's source register and the R1/R2 condition for that operand is false.
- R4: When both the memory-stage and write-back producers qualify for one operand, the select is 2'b10, so the newest result wins.
- R5: A producer whose destination is register 0 never causes forwarding, even when its write enable is 1 and the source is register 0.
- R6: A producer whose write enable is 0 never causes forwarding, whatever its destination.
- R7: When `ex_mem_read` is 1 and `ex_rt` equals `id_rs` or `id_rt`, then `hold_pc`, `hold_ifid` and `bubble_idex` are all 1.
- R8: When `ex_mem_read` is 0, or `ex_rt` matches neither `id_rs` nor `id_rt`, all three stall outputs are 0.
- R9: A select is 2'b00 (register-file value) when no producer qualifies. The code 2'b11 is never produced.
- R10: In the cycle after a load-use stall, the load sits in write-back and the bubble sits in the memory stage with its write enable cleared. The dependent operand then selects 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| mem_rd | input | 5 | Destination register held in the memory-stage register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register held in the write-back register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B |
| hold_pc | output | 1 | Keep the program counter unchanged this cycle |
| hold_ifid | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubble_idex | output | 1 | Zero the control fields written into the execute register |

## Verification
The hardest case to reach is the chain of three back-to-back writes to one register. Both forwarding producers match the same operand with their enables set, and only the priority decides the outcome. The directed stimulus places the same nonzero destination in both producer registers. It then clears the memory-stage enable alone to show the fallback to write-back. The load-use case is followed through two steps. First the stall is raised. Then comes the cycle after the bubble, where the load has advanced to write-back while the memory stage holds a non-writing empty slot.

// File: rtl/hazard_fwd_pkg.sv
package hazard_fwd_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } op_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hazard_prod_match.sv
module hazard_prod_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);

  logic dst_nonzero;

  always_comb begin
    dst_nonzero = |dst;
    hit         = wen && dst_nonzero && (dst == src);
  end

endmodule

// File: rtl/hazard_operand_sel.sv
module hazard_operand_sel
  import hazard_fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    sel
);

  logic mem_hit;
  logic wb_hit;
  op_sel_e sel_e;

  hazard_prod_match #(.AW(AW)) i_mem_match (
    .src (src),
    .dst (mem_rd),
    .wen (mem_wen),
    .hit (mem_hit)
  );

  hazard_prod_match #(.AW(AW)) i_wb_match (
    .src (src),
    .dst (wb_rd),
    .wen (wb_wen),
    .hit (wb_hit)
  );

  // Newer producer first: memory stage outranks write-back.
  always_comb begin
    if (mem_hit) begin
      sel_e = SEL_MEM;
    end else if (wb_hit) begin
      sel_e = SEL_WB;
    end else begin
      sel_e = SEL_REGFILE;
    end
    sel = sel_e;
  end

endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use #(
  parameter int unsigned AW = 5
) (
  input  logic          ex_mem_read,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          stall
);

  logic rs_dep;
  logic rt_dep;

  always_comb begin
    rs_dep = (ex_rt == id_rs);
    rt_dep = (ex_rt == id_rt);
    stall  = ex_mem_read && (rs_dep || rt_dep);
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic          ex_mem_read,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          bubble_idex
);

  logic [NUM_OPERANDS-1:0][AW-1:0] op_src;
  logic [NUM_OPERANDS-1:0][1:0]    op_sel;
  logic                            lu_stall;

  always_comb begin
    op_src[0] = ex_rs;
    op_src[1] = ex_rt;
  end

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
    hazard_operand_sel #(.AW(AW)) i_sel (
      .src     (op_src[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g])
    );
  end

  hazard_load_use #(.AW(AW)) i_load_use (
    .ex_mem_read (ex_mem_read),
    .ex_rt       (ex_rt),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .stall       (lu_stall)
  );

  always_comb begin
    fwd_a       = op_sel[0];
    fwd_b       = op_sel[1];
    hold_pc     = lu_stall;
    hold_ifid   = lu_stall;
    bubble_idex = lu_stall;
  end

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic          ex_mem_read,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          hold_pc,
  input logic          hold_ifid,
  input logic          bubble_idex
);

  logic known;

  always_comb begin
    known = !$isunknown({ex_rs, ex_rt, ex_mem_read, id_rs, id_rt,
                         mem_rd, mem_wen, wb_rd, wb_wen,
                         fwd_a, fwd_b, hold_pc, hold_ifid, bubble_idex});
    if (known) begin
      assert_mem_fwd_a_R1: assert (!(mem_wen && mem_rd != '0 && mem_rd == ex_rs)
                                   || fwd_a == 2'b10)
        else $error("operand A missed memory-stage forward");
      assert_mem_fwd_b_R2: assert (!(mem_wen && mem_rd != '0 && mem_rd == ex_rt)
                                   || fwd_b == 2'b10)
        else $error("operand B missed memory-stage forward");
      assert_wb_qual_a_R3: assert (fwd_a != 2'b01
                                   || (wb_wen && wb_rd == ex_rs))
        else $error("operand A write-back forward without qualifying producer");
      assert_no_zero_fwd_R5: assert (!(fwd_a == 2'b01 || fwd_b == 2'b01) || wb_rd != '0)
        else $error("forward from register zero");
      assert_no_code3_R9: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
        else $error("reserved select code produced");
      assert_stall_lines_R7: assert (hold_pc == hold_ifid && hold_ifid == bubble_idex)
        else $error("stall outputs disagree");
      assert_no_stall_R8: assert (ex_mem_read || !hold_pc)
        else $error("stall raised without a load in execute");
    end
  end

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] ex_rs = '0, ex_rt = '0, id_rs = '0, id_rt = '0;
  logic [4:0] mem_rd = '0, wb_rd = '0;
  logic       ex_mem_read = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic       hold_pc, hold_ifid, bubble_idex;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hazard_fwd_unit i_hazard_fwd_unit (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_mem_read(ex_mem_read),
    .id_rs(id_rs), .id_rt(id_rt),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_idex(bubble_idex)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] a_rs, a_rt, input logic a_ld,
                       input logic [4:0] d_rs, d_rt,
                       input logic [4:0] m_rd, input logic m_we,
                       input logic [4:0] w_rd, input logic w_we);
    @(negedge clk);
    ex_rs = a_rs; ex_rt = a_rt; ex_mem_read = a_ld;
    id_rs = d_rs; id_rt = d_rt;
    mem_rd = m_rd; mem_wen = m_we; wb_rd = w_rd; wb_wen = w_we;
    #1;
  endtask

  task automatic expect_out(input string req, input int a, input int b, input int st);
    chk({req, " fwd_a"}, fwd_a, a);
    chk({req, " fwd_b"}, fwd_b, b);
    chk({req, " hold_pc"}, hold_pc, st);
    chk({req, " hold_ifid"}, hold_ifid, st);
    chk({req, " bubble_idex"}, bubble_idex, st);
  endtask

  task automatic t_idle;
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_out("R9 idle", 0, 0, 0);
  endtask

  task automatic t_distance1;
    apply(3, 3, 0, 10, 11, 3, 1, 0, 0);
    expect_out("R1 R2 dist1 both", 2, 2, 0);
    apply(4, 3, 0, 10, 11, 3, 1, 0, 0);
    expect_out("R2 dist1 B only", 0, 2, 0);
    apply(3, 4, 0, 10, 11, 3, 1, 0, 0);
    expect_out("R1 dist1 A only", 2, 0, 0);
  endtask

  task automatic t_distance2;
    apply(7, 7, 0, 10, 11, 0, 0, 7, 1);
    expect_out("R3 dist2 both", 1, 1, 0);
    apply(7, 5, 0, 10, 11, 5, 1, 7, 1);
    expect_out("R3 mixed A wb B mem", 1, 2, 0);
  endtask

  task automatic t_distance3;
    apply(8, 9, 0, 10, 11, 2, 1, 6, 1);
    expect_out("R9 dist3 regfile", 0, 0, 0);
    apply(8, 8, 0, 10, 11, 8, 0, 8, 0);
    expect_out("R6 enables low", 0, 0, 0);
  endtask

  task automatic t_zero_reg;
    apply(0, 0, 0, 10, 11, 0, 1, 0, 0);
    expect_out("R5 mem rd zero", 0, 0, 0);
    apply(0, 0, 0, 10, 11, 0, 0, 0, 1);
    expect_out("R5 wb rd zero", 0, 0, 0);
  endtask

  task automatic t_triple_chain;
    apply(1, 1, 0, 10, 11, 1, 1, 1, 1);
    expect_out("R4 newest wins", 2, 2, 0);
    apply(1, 1, 0, 10, 11, 1, 0, 1, 1);
    expect_out("R4 fallback wb", 1, 1, 0);
  endtask

  task automatic t_load_use;
    apply(2, 9, 1, 9, 12, 0, 0, 0, 0);
    expect_out("R7 load-use rs", 0, 0, 1);
    apply(2, 9, 1, 12, 9, 0, 0, 0, 0);
    expect_out("R7 load-use rt", 0, 0, 1);
    apply(2, 9, 1, 12, 13, 0, 0, 0, 0);
    expect_out("R8 load no dep", 0, 0, 0);
    apply(2, 9, 0, 9, 9, 0, 0, 0, 0);
    expect_out("R8 not a load", 0, 0, 0);
    // cycle after the bubble: load in write-back, bubble in memory stage
    apply(9, 12, 0, 14, 15, 9, 0, 9, 1);
    expect_out("R10 post-stall forward", 1, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_distance1();
    t_distance2();
    t_distance3();
    t_zero_reg();
    t_triple_chain();
    t_load_use();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule